// File: doc/BRIEF.md
# Burst Address Generator with Repeat for a Synchronous RAM Port

This block generates the internal address for one port of a synchronous RAM. It also holds a small memory array, so the effect of each generated address can be seen through reads and writes. On every clock edge it picks the access address from one of three sources:

- an external address input;
- a burst counter that either advances or holds;
- a saved copy of the most recent externally loaded address.

The access in that cycle uses the chosen address.

All controls are active-low: load strobe, count enable, repeat and read/write. The counter is one value made of a bank field above an offset field. Carries pass from the offset into the bank, and the value wraps from the top of the last bank back to zero. A repeat takes the burst back to its starting point with no idle cycle between. A parameter selects the read path. In flow-through form, read data is visible after the edge that samples the address. In pipelined form it appears one clock later.

Top module: `burst_addr_port`

## Requirements
- R1: With the load strobe low at an edge, that cycle's access uses the external address, and the counter takes that value.
- R2: With the strobe and repeat high and count enable low, the counter increments by one first, and that cycle's access uses the incremented address.
- R3: With strobe, repeat and count enable all high, the counter holds, so successive accesses hit the same address.
- R4: With the strobe high and repeat low, the counter is restored to the saved load address, and the access in that same cycle uses it.
- R5: Only a strobe load updates the saved load address. A repeat, an increment, a hold, and the external address seen while the strobe is high leave it unchanged.
- R6: When controls conflict, the strobe wins over repeat, and repeat wins over count enable.
- R7: The counter value is {bank, offset}. Incrementing from offset all-ones in bank k gives offset 0 in bank k+1.
- R8: Incrementing from offset all-ones in the last bank (2^BANK_BITS - 1) gives offset 0 in bank 0.
- R9: With read/write low, the data input is written at the access address, and the data output does not change. With read/write high, the word at the access address is read.
- R10: With PIPE_OUT = 0, the word read at an edge is on dataOut right after that edge.
- R11: With PIPE_OUT = 1, dataOut shows the same words one clock later than in the flow-through form.
- R12: Reset (rstN low, asynchronous) clears the counter, the saved load address and the data output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| adsN | input | 1 | Load strobe: take extAddr (active low) |
| cntEnN | input | 1 | Counter increment enable (active low) |
| rptN | input | 1 | Restore the saved load address (active low) |
| rwN | input | 1 | Low writes, high reads |
| extAddr | input | BANK_BITS+OFS_BITS | External address {bank, offset} |
| dataIn | input | DATA_W | Write data |
| dataOut | output | DATA_W | Read data |
| accessAddr | output | BANK_BITS+OFS_BITS | Address used by the most recent access |

## Verification
The properties assume that every control is a clean 0 or 1 at each rising edge, and that the memory index is the low MEM_AW bits of the address. They do not model the memory contents, so data values are checked only by the bench. The bench changes inputs only on falling edges and keeps every control at a defined level, including during reset. Because it uses a small array, aliasing between bank-boundary addresses is predictable, and the expected data already accounts for it.

// File: rtl/bap_pkg.sv
package bap_pkg;

  // Decoded per-cycle command from control to datapath
  typedef struct packed {
    logic loadExt;   // take the external address
    logic reload;    // restore the saved load address
    logic advance;   // increment the counter
    logic doWrite;   // store dataIn at the access address
    logic doRead;    // capture the word at the access address
  } bap_ctl_t;

endpackage

// File: rtl/bap_ctrl.sv
module bap_ctrl
  import bap_pkg::*;
(
  input  logic     adsN,
  input  logic     cntEnN,
  input  logic     rptN,
  input  logic     rwN,
  output bap_ctl_t ctl
);

  // Fixed priority: strobe, then repeat, then count enable, else hold
  always_comb begin
    ctl = '0;
    if (!adsN) begin
      ctl.loadExt = 1'b1;
    end else if (!rptN) begin
      ctl.reload = 1'b1;
    end else if (!cntEnN) begin
      ctl.advance = 1'b1;
    end
    ctl.doWrite = !rwN;
    ctl.doRead  = rwN;
  end

endmodule

// File: rtl/bap_dpath.sv
module bap_dpath
  import bap_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 36,
  parameter int MEM_AW   = 10,
  parameter bit PIPE_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bap_ctl_t          ctl,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] accessAddr,
  output logic [DATA_W-1:0] dataOut
);

  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic [ADDR_W-1:0] cntReg;
  logic [ADDR_W-1:0] savedAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [MEM_AW-1:0] memIdx;
  logic [DATA_W-1:0] flowReg;
  logic [DATA_W-1:0] memArr [MEM_DEPTH];

  // Address source for this cycle; the increment wraps at the full width
  always_comb begin
    if (ctl.loadExt)      nextAddr = extAddr;
    else if (ctl.reload)  nextAddr = savedAddr;
    else if (ctl.advance) nextAddr = cntReg + ADDR_W'(1);
    else                  nextAddr = cntReg;
  end

  assign memIdx = nextAddr[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg    <= '0;
      savedAddr <= '0;
    end else begin
      cntReg <= nextAddr;
      if (ctl.loadExt) savedAddr <= extAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.doWrite) memArr[memIdx] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flowReg <= '0;
    end else if (ctl.doRead) begin
      flowReg <= memArr[memIdx];
    end
  end

  generate
    if (PIPE_OUT) begin : g_pipe
      logic [DATA_W-1:0] pipeReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipeReg <= '0;
        else       pipeReg <= flowReg;
      end
      assign dataOut = pipeReg;
    end else begin : g_flow
      assign dataOut = flowReg;
    end
  endgenerate

  assign accessAddr = cntReg;

endmodule

// File: rtl/burst_addr_port.sv
module burst_addr_port
  import bap_pkg::*;
#(
  parameter int BANK_BITS = 6,
  parameter int OFS_BITS  = 12,
  parameter int DATA_W    = 36,
  parameter int MEM_AW    = 10,
  parameter bit PIPE_OUT  = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          adsN,
  input  logic                          cntEnN,
  input  logic                          rptN,
  input  logic                          rwN,
  input  logic [BANK_BITS+OFS_BITS-1:0] extAddr,
  input  logic [DATA_W-1:0]             dataIn,
  output logic [DATA_W-1:0]             dataOut,
  output logic [BANK_BITS+OFS_BITS-1:0] accessAddr
);

  localparam int ADDR_W = BANK_BITS + OFS_BITS;

  bap_ctl_t ctl;

  bap_ctrl u_ctrl (
    .adsN   (adsN),
    .cntEnN (cntEnN),
    .rptN   (rptN),
    .rwN    (rwN),
    .ctl    (ctl)
  );

  bap_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MEM_AW   (MEM_AW),
    .PIPE_OUT (PIPE_OUT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .extAddr    (extAddr),
    .dataIn     (dataIn),
    .accessAddr (accessAddr),
    .dataOut    (dataOut)
  );

endmodule

// File: rtl/bap_checker.sv
module bap_checker #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 36,
  parameter bit PIPE_OUT = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              adsN,
  input logic              cntEnN,
  input logic              rptN,
  input logic              rwN,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] accessAddr,
  input logic [DATA_W-1:0] dataOut
);

  // Independent record of the last strobe-loaded address
  logic [ADDR_W-1:0] shadowLoad;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      shadowLoad <= '0;
    else if (!adsN) shadowLoad <= extAddr;
  end

  // R1 and R6: the strobe wins whatever the other controls are
  a_r1_strobe_load: assert property (@(posedge clk) disable iff (!rstN)
    !adsN |=> accessAddr == $past(extAddr));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rstN)
    (adsN && rptN && !cntEnN) |=> (accessAddr - $past(accessAddr)) == ADDR_W'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (adsN && rptN && cntEnN) |=> $stable(accessAddr));

  // R4, R5 and R6: repeat restores the shadow value even with count enable low
  a_r4_repeat: assert property (@(posedge clk) disable iff (!rstN)
    (adsN && !rptN) |=> accessAddr == $past(shadowLoad));

  generate
    if (PIPE_OUT) begin : g_pipe_chk
      a_r9_write_keeps_out: assert property (@(posedge clk) disable iff (!rstN)
        (!rwN && $past(!rwN)) |=> $stable(dataOut));
    end else begin : g_flow_chk
      a_r9_write_keeps_out: assert property (@(posedge clk) disable iff (!rstN)
        !rwN |=> $stable(dataOut));
    end
  endgenerate

endmodule

bind burst_addr_port bap_checker #(
  .ADDR_W   (BANK_BITS + OFS_BITS),
  .DATA_W   (DATA_W),
  .PIPE_OUT (PIPE_OUT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .adsN       (adsN),
  .cntEnN     (cntEnN),
  .rptN       (rptN),
  .rwN        (rwN),
  .extAddr    (extAddr),
  .accessAddr (accessAddr),
  .dataOut    (dataOut)
);

// File: tb/sim_burst_addr_port.sv
module sim_burst_addr_port;

  localparam int CLK_PERIOD = 10;
  localparam int BANK_BITS  = 6;
  localparam int OFS_BITS   = 12;
  localparam int ADDR_W     = BANK_BITS + OFS_BITS;
  localparam int DATA_W     = 16;
  localparam int MEM_AW     = 8;

  typedef struct packed {
    logic              adsN;
    logic              cntEnN;
    logic              rptN;
    logic              rwN;
    logic [ADDR_W-1:0] ext;
    logic [DATA_W-1:0] din;
    logic [ADDR_W-1:0] expAddr;
    logic [DATA_W-1:0] expData;
    logic [7:0]        req;
  } vec_t;

  localparam int NVEC = 20;
  // Fields: ads cnt rpt rw ext din expAddr expData(flow-through) req
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b1,1'b1,1'b0,18'h00010,16'hA001,18'h00010,16'h0000,8'd1},  // R1 load, write
    '{1'b1,1'b0,1'b1,1'b0,18'h00000,16'hA002,18'h00011,16'h0000,8'd2},  // R2 advance, write
    '{1'b1,1'b0,1'b1,1'b0,18'h00000,16'hA003,18'h00012,16'h0000,8'd2},  // R2
    '{1'b1,1'b1,1'b1,1'b0,18'h00000,16'hA004,18'h00012,16'h0000,8'd3},  // R3 hold, overwrite
    '{1'b1,1'b1,1'b0,1'b1,18'h00000,16'h0000,18'h00010,16'hA001,8'd4},  // R4 repeat, read
    '{1'b1,1'b0,1'b1,1'b1,18'h00000,16'h0000,18'h00011,16'hA002,8'd9},  // R9 read back
    '{1'b1,1'b0,1'b1,1'b1,18'h00000,16'h0000,18'h00012,16'hA004,8'd10}, // R10
    '{1'b1,1'b1,1'b1,1'b1,18'h00000,16'h0000,18'h00012,16'hA004,8'd3},  // R3
    '{1'b1,1'b1,1'b0,1'b1,18'h00003,16'h0000,18'h00010,16'hA001,8'd5},  // R5 saved unchanged
    '{1'b0,1'b0,1'b0,1'b1,18'h00011,16'h0000,18'h00011,16'hA002,8'd6},  // R6 strobe wins
    '{1'b1,1'b0,1'b0,1'b1,18'h00000,16'h0000,18'h00011,16'hA002,8'd6},  // R6 repeat over count
    '{1'b0,1'b1,1'b1,1'b0,18'h00FFF,16'hB001,18'h00FFF,16'hA002,8'd9},  // R9 write keeps out
    '{1'b1,1'b0,1'b1,1'b0,18'h00000,16'hB002,18'h01000,16'hA002,8'd7},  // R7 bank carry
    '{1'b0,1'b1,1'b1,1'b1,18'h00FFF,16'h0000,18'h00FFF,16'hB001,8'd7},  // R7
    '{1'b1,1'b0,1'b1,1'b1,18'h00000,16'h0000,18'h01000,16'hB002,8'd7},  // R7
    '{1'b0,1'b1,1'b1,1'b0,18'h3FFFF,16'hC001,18'h3FFFF,16'hB002,8'd8},  // R8 top of last bank
    '{1'b1,1'b0,1'b1,1'b0,18'h00000,16'hC002,18'h00000,16'hB002,8'd8},  // R8 wrap to zero
    '{1'b1,1'b1,1'b0,1'b1,18'h00000,16'h0000,18'h3FFFF,16'hC001,8'd4},  // R4
    '{1'b1,1'b0,1'b1,1'b1,18'h00000,16'h0000,18'h00000,16'hC002,8'd8},  // R8
    '{1'b0,1'b1,1'b1,1'b1,18'h00FFF,16'h0000,18'h00FFF,16'hC001,8'd1}   // R1
  };

  logic              clk;
  logic              rstN;
  logic              adsN, cntEnN, rptN, rwN;
  logic [ADDR_W-1:0] extAddr;
  logic [DATA_W-1:0] dataIn;
  logic [DATA_W-1:0] dataOut, dataOutP;
  logic [ADDR_W-1:0] accessAddr, accessAddrP;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  burst_addr_port #(
    .BANK_BITS(BANK_BITS), .OFS_BITS(OFS_BITS), .DATA_W(DATA_W),
    .MEM_AW(MEM_AW), .PIPE_OUT(1'b0)
  ) u0 (
    .clk(clk), .rstN(rstN), .adsN(adsN), .cntEnN(cntEnN), .rptN(rptN),
    .rwN(rwN), .extAddr(extAddr), .dataIn(dataIn),
    .dataOut(dataOut), .accessAddr(accessAddr)
  );

  burst_addr_port #(
    .BANK_BITS(BANK_BITS), .OFS_BITS(OFS_BITS), .DATA_W(DATA_W),
    .MEM_AW(MEM_AW), .PIPE_OUT(1'b1)
  ) u1 (
    .clk(clk), .rstN(rstN), .adsN(adsN), .cntEnN(cntEnN), .rptN(rptN),
    .rwN(rwN), .extAddr(extAddr), .dataIn(dataIn),
    .dataOut(dataOutP), .accessAddr(accessAddrP)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic c, input logic r, input logic w,
                       input logic [ADDR_W-1:0] e, input logic [DATA_W-1:0] d);
    adsN = a; cntEnN = c; rptN = r; rwN = w; extAddr = e; dataIn = d;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [DATA_W-1:0] prevExp;
    rstN = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    step(); step();
    // R12 reset state
    check("R12 addr after reset", 32'(accessAddr), 32'h0);
    check("R12 dout after reset", 32'(dataOut), 32'h0);
    check("R12 pipelined dout after reset", 32'(dataOutP), 32'h0);
    rstN = 1'b1;
    prevExp = '0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].adsN, VEC[i].cntEnN, VEC[i].rptN, VEC[i].rwN, VEC[i].ext, VEC[i].din);
      step();
      check($sformatf("R%0d row %0d addr", VEC[i].req, i), 32'(accessAddr), 32'(VEC[i].expAddr));
      check($sformatf("R10 row %0d flow-through data", i), 32'(dataOut), 32'(VEC[i].expData));
      check($sformatf("R11 row %0d pipelined data", i), 32'(dataOutP), 32'(prevExp));
      prevExp = VEC[i].expData;
    end

    // R11 last word still reaches the pipelined output one clock later
    drive(1'b1, 1'b1, 1'b1, 1'b0, '0, 16'hDEAD);
    step();
    check("R11 pipelined final word", 32'(dataOutP), 32'(prevExp));
    check("R9 write leaves flow-through output", 32'(dataOut), 32'(prevExp));

    // R12 mid-run reset clears counter, saved address and outputs
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R12 async reset addr", 32'(accessAddr), 32'h0);
    check("R12 async reset dout", 32'(dataOut), 32'h0);
    check("R12 async reset pipelined dout", 32'(dataOutP), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 18'h00055, '0);
    step();
    check("R2 increment from reset value", 32'(accessAddr), 32'h1);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 18'h00055, '0);
    step();
    check("R12 saved address cleared by reset", 32'(accessAddr), 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule